// File: doc/BRIEF.md
# Token-Passing Chain Readout Controller

Several front-end chips share one data bus and are read one after another along a daisy chain. Each chip has one copy of this controller. When a readout phase is open, a chip waits for the token on its input. On receiving it, the chip fetches its stored words from local memory in ascending address order and drives them onto the shared bus, one per cycle, each with a valid strobe. After the last word it releases the bus and passes the token to the next chip as a single-cycle pulse. A chip holding no events does not touch the bus and passes the token on at once.

The number of stored events comes from the local memory's event counter. It is sampled when the token arrives, clamped to the depth of the event store, and multiplied by a fixed number of words per event. The memory read port has one cycle of latency. Once the token has been passed, the chip is idle again. Outside the readout phase it ignores any token.

Top module: `tokro_ctrl`

## Requirements
- R1: A token on `tok_in` is accepted only when the chip is idle and `readout_en` is high. A token arriving at any other time is ignored: no reads, no bus activity, no `tok_out` and no `busy`.
- R2: For an accepted token with N = min(evt_count, MAX_EVT) > 0, the block asserts `mem_rd_en` for exactly N*WORDS_PER_EVT consecutive cycles. These start in the cycle after token-in was sampled and present the addresses 0, 1, 2, and so on in ascending order.
- R3: The memory returns data one cycle after `mem_rd_en`. Each word appears on `bus_data` with `bus_valid` high two cycles after its read request, in read order and with no gaps.
- R4: When the event count is zero, `tok_out` pulses in the cycle right after token-in was sampled. No memory read is made and `bus_oe` never rises.
- R5: `tok_out` is a single-cycle pulse in the cycle right after the last word was valid on the bus.
- R6: `bus_oe` is high from the cycle after token-in through the cycle of the last word. It is low while `tok_out` is high. `bus_data` reads zero whenever `bus_oe` is low, and `bus_valid` is never high without `bus_oe`.
- R7: `busy` is high from the cycle after token-in through the `tok_out` cycle and low at all other times, including right after reset.
- R8: An event count above MAX_EVT is treated as MAX_EVT.
- R9: After `tok_out` the chip is idle and accepts a new token in the readout phase without any extra cycle.
- R10: The event count is sampled only when the token is accepted. Changes to it during the readout do not change the number of words sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| readout_en | input | 1 | Readout phase open (conversion finished) |
| tok_in | input | 1 | Token from the previous chip in the chain |
| evt_count | input | CNT_W | Number of stored events, from local memory |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after a read request |
| tok_out | output | 1 | Single-cycle token pulse to the next chip |
| busy | output | 1 | Chip holds the token |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address |
| bus_data | output | DATA_W | Data toward the shared bus, zero when not driving |
| bus_oe | output | 1 | Output enable for the shared bus driver |
| bus_valid | output | 1 | A data word is on the bus this cycle |

## Verification
The bench uses the default build: MAX_EVT=5, WORDS_PER_EVT=2 and a 4-bit event count. With these values a full store takes ten words, and counts from 6 to 15 reach the clamp. Every cycle of each readout is compared against a timeline computed from the count: read cycles, addresses, data words, enable, busy and the token pulse position. Zero-count chains, back-to-back tokens, tokens outside the phase or during a readout, and counts that change mid-readout are all within reach.

// File: rtl/tokro_pkg.sv
package tokro_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HAND  = 2'd3
  } tok_state_e;

  // Event count limited to the depth of the event store
  function automatic int unsigned clamp_events(int unsigned cnt, int unsigned max_evt);
    return (cnt > max_evt) ? max_evt : cnt;
  endfunction

  // Number of bus words a chip sends for a given event count
  function automatic int unsigned word_total(int unsigned cnt, int unsigned max_evt,
                                             int unsigned wpe);
    return clamp_events(cnt, max_evt) * wpe;
  endfunction

endpackage

// File: rtl/tokro_fsm.sv
module tokro_fsm
  import tokro_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       readout_en,
  input  logic       tok_in,
  input  logic       zero_evt,
  input  logic       fetch_done,
  input  logic       last_word,
  output logic       accept,
  output logic       fetch_active,
  output logic       tok_out,
  output logic       busy,
  output logic       bus_oe
);

  tok_state_e st_q, st_d;

  assign accept = (st_q == ST_IDLE) && readout_en && tok_in;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = zero_evt ? ST_HAND : ST_FETCH;
      ST_FETCH: if (last_word) st_d = ST_HAND;
                else if (fetch_done) st_d = ST_DRAIN;
      ST_DRAIN: if (last_word) st_d = ST_HAND;
      ST_HAND:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign fetch_active = (st_q == ST_FETCH);
  assign tok_out      = (st_q == ST_HAND);
  assign busy         = (st_q != ST_IDLE);
  assign bus_oe       = (st_q == ST_FETCH) || (st_q == ST_DRAIN);

  AST_IGNORE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !(readout_en && tok_in)) |=> !busy); // R1
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_evt) |=> (tok_out && !bus_oe)); // R4
  AST_TOKOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out); // R5
  AST_OE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> tok_out); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tok_out)); // R7

endmodule

// File: rtl/tokro_fetch.sv
module tokro_fetch
  import tokro_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_EVT = 5,
  parameter int WPE     = 2,
  parameter int TOT_W   = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  evt_count,
  input  logic              active,
  output logic [TOT_W-1:0]  total,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fetch_done,
  output logic              rd_issued
);

  logic [TOT_W-1:0] total_q;
  logic [TOT_W-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q   <= '0;
      rd_ptr    <= '0;
      rd_issued <= 1'b0;
    end else begin
      rd_issued <= mem_rd_en;
      if (load) begin
        total_q <= TOT_W'(word_total(32'(evt_count), MAX_EVT, WPE));
        rd_ptr  <= '0;
      end else if (mem_rd_en) begin
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end

  assign total      = total_q;
  assign fetch_done = (rd_ptr == total_q);
  assign mem_rd_en  = active && !fetch_done;
  assign mem_addr   = ADDR_W'(rd_ptr);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= total_q); // R2
  AST_TOTAL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(total_q) <= MAX_EVT * WPE); // R8

endmodule

// File: rtl/tokro_out.sv
module tokro_out #(
  parameter int DATA_W = 16,
  parameter int TOT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic [TOT_W-1:0]  total,
  input  logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid,
  output logic              last_word
);

  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic [TOT_W-1:0]  sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      sent_q  <= '0;
    end else begin
      valid_q <= rd_issued;
      if (rd_issued) data_q <= mem_rd_data;
      if (load)         sent_q <= '0;
      else if (valid_q) sent_q <= sent_q + 1'b1;
    end
  end

  assign last_word = valid_q && (sent_q == total - TOT_W'(1));
  assign bus_data  = bus_oe ? data_q : '0;
  assign bus_valid = valid_q;

  AST_VALID_IN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_oe); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !last_word) |=> bus_valid); // R3

endmodule

// File: rtl/tokro_ctrl.sv
module tokro_ctrl
  import tokro_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CNT_W         = 4,
  parameter int MAX_EVT       = 5,
  parameter int WORDS_PER_EVT = 2,
  localparam int MAX_WORDS    = MAX_EVT * WORDS_PER_EVT,
  localparam int TOT_W        = $clog2(MAX_WORDS + 1),
  localparam int ADDR_W       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              readout_en,
  input  logic              tok_in,
  input  logic [CNT_W-1:0]  evt_count,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tok_out,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              bus_valid
);

  logic             accept;
  logic             fetch_active;
  logic             fetch_done;
  logic             rd_issued;
  logic             last_word;
  logic             zero_evt;
  logic [TOT_W-1:0] total;

  assign zero_evt = (evt_count == '0);

  tokro_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .readout_en   (readout_en),
    .tok_in       (tok_in),
    .zero_evt     (zero_evt),
    .fetch_done   (fetch_done),
    .last_word    (last_word),
    .accept       (accept),
    .fetch_active (fetch_active),
    .tok_out      (tok_out),
    .busy         (busy),
    .bus_oe       (bus_oe)
  );

  tokro_fetch #(
    .CNT_W   (CNT_W),
    .MAX_EVT (MAX_EVT),
    .WPE     (WORDS_PER_EVT),
    .TOT_W   (TOT_W),
    .ADDR_W  (ADDR_W)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .evt_count  (evt_count),
    .active     (fetch_active),
    .total      (total),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .fetch_done (fetch_done),
    .rd_issued  (rd_issued)
  );

  tokro_out #(
    .DATA_W (DATA_W),
    .TOT_W  (TOT_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .rd_issued   (rd_issued),
    .mem_rd_data (mem_rd_data),
    .total       (total),
    .bus_oe      (bus_oe),
    .bus_data    (bus_data),
    .bus_valid   (bus_valid),
    .last_word   (last_word)
  );

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (busy && bus_oe)); // R4

endmodule

// File: tb/tokro_ctrl_tb.sv
module tokro_ctrl_tb;

  localparam int DATA_W  = 16;
  localparam int CNT_W   = 4;
  localparam int MAX_EVT = 5;
  localparam int WPE     = 2;
  localparam int ADDR_W  = $clog2(MAX_EVT * WPE);
  localparam int WIN     = MAX_EVT * WPE + 6;

  // {readout_en, evt_count}
  localparam logic [4:0] VEC [0:8] = '{
    5'h15, 5'h13, 5'h11, 5'h10, 5'h10, 5'h03, 5'h19, 5'h1F, 5'h12
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              readout_en;
  logic              tok_in;
  logic [CNT_W-1:0]  evt_count;
  logic [DATA_W-1:0] mem_rd_data;
  logic              tok_out, busy, mem_rd_en, bus_oe, bus_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] bus_data;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  tokro_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .readout_en  (readout_en),
    .tok_in      (tok_in),
    .evt_count   (evt_count),
    .mem_rd_data (mem_rd_data),
    .tok_out     (tok_out),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .bus_data    (bus_data),
    .bus_oe      (bus_oe),
    .bus_valid   (bus_valid)
  );

  function automatic logic [DATA_W-1:0] pat(int a);
    return 16'hC300 ^ DATA_W'(a * 16'h0111);
  endfunction

  // Local memory model: one-cycle read latency
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= pat(int'(mem_addr));
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pass one token and compare every cycle against the expected timeline.
  task automatic run_token(int cnt, bit en, bit retok, int cnt_mid, string tag);
    int n, tok_idx;
    int rd_err = 0, v_err = 0, oe_err = 0, to_err = 0, busy_err = 0;
    @(negedge clk);
    evt_count  = CNT_W'(cnt);
    readout_en = en;
    tok_in     = 1'b1;
    n = en ? ((cnt > MAX_EVT) ? MAX_EVT : cnt) * WPE : 0;
    tok_idx = !en ? -1 : ((n == 0) ? 1 : n + 3);
    for (int idx = 1; idx <= WIN; idx++) begin
      @(negedge clk);
      if (idx == 1) begin
        tok_in    = 1'b0;
        evt_count = CNT_W'(cnt_mid);
      end
      if (retok && idx == 2) tok_in = 1'b1;
      if (retok && idx == 3) tok_in = 1'b0;
      begin
        bit exp_rd, exp_v, exp_oe;
        exp_rd = en && n > 0 && idx <= n;
        if (mem_rd_en !== exp_rd) rd_err++;
        else if (exp_rd && int'(mem_addr) != idx - 1) rd_err++;
        exp_v = en && n > 0 && idx >= 3 && idx <= n + 2;
        if (bus_valid !== exp_v) v_err++;
        else if (exp_v && bus_data !== pat(idx - 3)) v_err++;
        exp_oe = en && n > 0 && idx <= n + 2;
        if (bus_oe !== exp_oe) oe_err++;
        if (!bus_oe && bus_data !== '0) oe_err++;
        if (tok_out !== (idx == tok_idx)) to_err++;
        if (busy !== (en && idx <= tok_idx)) busy_err++;
      end
    end
    tok_in = 1'b0;
    chk(rd_err == 0,   {tag, " R2 R4 read cycles/addresses"}, rd_err, 0);
    chk(v_err == 0,    {tag, " R3 bus words"}, v_err, 0);
    chk(oe_err == 0,   {tag, " R6 output enable"}, oe_err, 0);
    chk(to_err == 0,   {tag, " R5 token pulse"}, to_err, 0);
    chk(busy_err == 0, {tag, " R7 busy window"}, busy_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    readout_en = 1'b0;
    tok_in     = 1'b0;
    evt_count  = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && tok_out == 1'b0, "R7 reset busy/token", int'(busy), 0);
    chk(bus_oe == 1'b0 && bus_valid == 1'b0 && mem_rd_en == 1'b0,
        "R6 reset bus idle", int'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: back-to-back tokens also exercise R9
    foreach (VEC[i]) begin
      int  c;
      bit  e;
      string tag;
      c = int'(VEC[i][3:0]);
      e = VEC[i][4];
      if (!e)               tag = "R1 out-of-phase";
      else if (c > MAX_EVT) tag = "R8 clamp";
      else if (c == 0)      tag = "R4 zero-count";
      else                  tag = "R9 chain";
      run_token(c, e, 1'b0, c, tag);
    end

    // R10: count changes during the readout
    run_token(2, 1'b1, 1'b0, 5, "R10 count change");
    // R1: second token during a readout is ignored
    run_token(3, 1'b1, 1'b1, 3, "R1 token while busy");
    // R1: token while the phase is closed, then R9 a normal readout
    run_token(4, 1'b0, 1'b0, 4, "R1 phase closed");
    run_token(1, 1'b1, 1'b0, 1, "R9 after ignore");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule